// File: doc/BRIEF.md
# Video Pipeline Bypass Sequencer

This block is a control state machine. It sits beside a video pipeline that can send a stream either through a deinterlacer or around it. It watches the lock and format status that a video input receiver reports: the lock flags, the interlace flag, the two field heights, the active width and the colour-space code. From these it decides when the input can be trusted and which route the stream must take. It then drives the run and route controls of an upstream stream switch and a downstream stream switch, the run control of the deinterlacer, and the discard modes of the upstream switch and of the mixer input that takes the processed stream.

When the input becomes unusable while the pipe is running, the sequencer takes two actions. It puts the mixer input and the upstream switch into discard, so that the display keeps a clean background and no oversized frame reaches the deinterlacer. It also records the frame buffer's frame count at that moment. When a stable format comes back, the sequencer rebuilds the route one step per cycle. Throughout the rebuild, no switch is running while its routing changes, and the downstream logic is allowed to drain first. After the route is built, the sequencer releases the upstream discard. It keeps the mixer in discard until enough frames have passed through the frame buffer to wash out stale content.

Top module: `vid_bypass_seq`

## Requirements
- R1: While reset is low, the outputs hold a safe state: both switches stopped, both upstream outputs disabled, downstream select 0, deinterlacer stopped, upstream discard high and mixer discard high.
- R2: A format is accepted only when both `rx_locked` and `rx_stable` are high and the derived format equals the previous sample. With `rx_locked` high and `rx_stable` low, the sequencer neither starts a reconfiguration nor leaves the running state.
- R3: In the running state, the sequencer leaves that state and raises both `mix_discard` and `up_discard` one cycle after any of these holds: `rx_locked` is low; the derived width, derived height or colour code differs from the previous sample; the derived width exceeds 3840; the derived height exceeds 2160. In the same cycle it records `fb_count`. No reconfiguration starts while any of these conditions persists.
- R4: The derived height is `field0_h + field1_h` when `rx_interlaced` is high and `field0_h` otherwise. The derived width is `width_px` doubled when `color_code` equals 3 (4:2:0 sampling) and `width_px` otherwise. The limits in R3 apply to the derived values.
- R5: An accepted interlaced format selects the deinterlace route. Any accepted progressive format, 3840x2160 included, selects the bypass route.
- R6: Reconfiguration proceeds one step per cycle in this order: stop the downstream switch, then stop the upstream switch, then wait while `down_busy` is high, then program the routes, then start the downstream switch.
- R7: For bypass, `up_out0_en`=1, `up_out1_en`=0 and `dn_sel`=0; the upstream switch starts first and the deinterlacer stops one cycle later. For the deinterlace route, `up_out0_en`=0, `up_out1_en`=1 and `dn_sel`=1; the deinterlacer starts first and the upstream switch starts one cycle later.
- R8: `up_discard` falls one cycle after the last route step, and the pipe then counts as running.
- R9: In the running state with an accepted format, `mix_discard` falls only on a cycle where `fb_count` differs from its value in the previous cycle and has advanced by at least 10 past the recorded count. While the pipe is not running, `mix_discard` stays high.
- R10: The advance in R9 is taken modulo 2^FCNT_W, so the release still happens when the counter wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| rx_locked | input | 1 | Receiver general lock flag |
| rx_stable | input | 1 | Receiver format-stable lock flag |
| rx_interlaced | input | 1 | Receiver reports interlaced input |
| field0_h | input | HEIGHT_W | Height of the first field (or frame) |
| field1_h | input | HEIGHT_W | Height of the second field |
| width_px | input | WIDTH_W | Reported active width |
| color_code | input | CS_W | Colour-space code; 3 means 4:2:0 |
| down_busy | input | 1 | Unit after the downstream switch still holds video |
| fb_count | input | FCNT_W | Frame buffer output frame counter |
| up_run | output | 1 | Upstream switch run |
| up_out0_en | output | 1 | Upstream output 0 (bypass path) enable |
| up_out1_en | output | 1 | Upstream output 1 (deinterlacer path) enable |
| up_discard | output | 1 | Upstream switch discards its input |
| dn_run | output | 1 | Downstream switch run |
| dn_sel | output | 1 | Downstream input select: 0 bypass, 1 deinterlacer |
| dil_run | output | 1 | Deinterlacer run |
| mix_discard | output | 1 | Mixer input discards the pipe stream |

## Verification
The bench drives three groups of formats. The first group is 1080-line progressive, 1080-line interlaced as two 540-line fields, and 3840-wide 4:2:0 and 4:4:4 input; these show that the route depends only on the interlace flag, even at 4K. The second group is a set of rejected inputs: a dropped lock, a change of one field height, a width that is legal before doubling but too wide after it, and a height just above the limit. Each of these must leave the switches untouched until the input becomes acceptable. The third group is a frame counter that creeps upward from just below the release threshold and across its wrap point; this separates a correct modulo comparison from an absolute one. A long `down_busy` pulse shows that the routing waits for the drain.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE     = 4'd0,
    ST_STOP_DN  = 4'd1,
    ST_STOP_UP  = 4'd2,
    ST_DRAIN    = 4'd3,
    ST_ROUTE    = 4'd4,
    ST_START_DN = 4'd5,
    ST_TAIL_A   = 4'd6,
    ST_TAIL_B   = 4'd7,
    ST_RELEASE  = 4'd8,
    ST_ACTIVE   = 4'd9
  } seq_state_t;

  typedef enum logic {
    ROUTE_BYPASS = 1'b0,
    ROUTE_DEINT  = 1'b1
  } route_t;

  typedef struct packed {
    logic up_run;
    logic up_out0;
    logic up_out1;
    logic up_discard;
    logic dn_run;
    logic dn_sel;
    logic dil_run;
    logic mix_discard;
  } ctl_t;

  localparam ctl_t CTL_SAFE = '{
    up_run:      1'b0,
    up_out0:     1'b0,
    up_out1:     1'b0,
    up_discard:  1'b1,
    dn_run:      1'b0,
    dn_sel:      1'b0,
    dil_run:     1'b0,
    mix_discard: 1'b1
  };

endpackage

// File: rtl/vbs_fmt_monitor.sv
module vbs_fmt_monitor #(
  parameter int WIDTH_W   = 13,
  parameter int HEIGHT_W  = 12,
  parameter int CS_W      = 8,
  parameter int MAX_W     = 3840,
  parameter int MAX_H     = 2160,
  parameter int Y420_CODE = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_en,
  input  logic                rx_locked,
  input  logic                rx_stable,
  input  logic                rx_interlaced,
  input  logic [HEIGHT_W-1:0] field0_h,
  input  logic [HEIGHT_W-1:0] field1_h,
  input  logic [WIDTH_W-1:0]  width_px,
  input  logic [CS_W-1:0]     color_code,
  output logic                fmt_bad,
  output logic                fmt_good
);

  localparam int EW_W = WIDTH_W + 1;
  localparam int EH_W = HEIGHT_W + 1;
  localparam logic [EW_W-1:0] MAX_W_V = EW_W'(MAX_W);
  localparam logic [EH_W-1:0] MAX_H_V = EH_W'(MAX_H);
  localparam logic [CS_W-1:0] Y420_V  = CS_W'(Y420_CODE);

  logic [EW_W-1:0] eff_w;
  logic [EH_W-1:0] eff_h;
  logic [EW_W-1:0] prev_w_q, prev_w_d;
  logic [EH_W-1:0] prev_h_q, prev_h_d;
  logic [CS_W-1:0] prev_cs_q, prev_cs_d;
  logic            changed;
  logic            oversize;

  always_comb begin
    if (color_code == Y420_V) eff_w = {width_px, 1'b0};
    else                      eff_w = {1'b0, width_px};
    if (rx_interlaced) eff_h = {1'b0, field0_h} + {1'b0, field1_h};
    else               eff_h = {1'b0, field0_h};
  end

  always_comb begin
    changed  = (eff_w != prev_w_q) || (eff_h != prev_h_q) || (color_code != prev_cs_q);
    oversize = (eff_w > MAX_W_V) || (eff_h > MAX_H_V);
    fmt_bad  = !rx_locked || changed || oversize;
    fmt_good = !fmt_bad && rx_stable;
  end

  always_comb begin
    prev_w_d  = prev_w_q;
    prev_h_d  = prev_h_q;
    prev_cs_d = prev_cs_q;
    if (sample_en) begin
      prev_w_d  = eff_w;
      prev_h_d  = eff_h;
      prev_cs_d = color_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_w_q  <= '0;
      prev_h_q  <= '0;
      prev_cs_q <= '0;
    end else begin
      prev_w_q  <= prev_w_d;
      prev_h_q  <= prev_h_d;
      prev_cs_q <= prev_cs_d;
    end
  end

endmodule

// File: rtl/vbs_flush_tracker.sv
module vbs_flush_tracker #(
  parameter int FCNT_W       = 8,
  parameter int FLUSH_FRAMES = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FCNT_W-1:0] fb_count,
  input  logic              latch_en,
  output logic              advanced,
  output logic              flushed
);

  localparam logic [FCNT_W-1:0] FLUSH_V = FCNT_W'(FLUSH_FRAMES);

  logic [FCNT_W-1:0] prev_q;
  logic [FCNT_W-1:0] orig_q, orig_d;
  logic [FCNT_W-1:0] distance;

  always_comb begin
    distance = fb_count - orig_q;
    advanced = (fb_count != prev_q);
    flushed  = (distance >= FLUSH_V);
    orig_d   = latch_en ? fb_count : orig_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      orig_q <= '0;
    end else begin
      prev_q <= fb_count;
      orig_q <= orig_d;
    end
  end

endmodule

// File: rtl/vbs_route_fsm.sv
module vbs_route_fsm
  import vbs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fmt_bad,
  input  logic fmt_good,
  input  logic rx_interlaced,
  input  logic down_busy,
  input  logic advanced,
  input  logic flushed,
  output ctl_t ctl,
  output logic sample_en,
  output logic latch_en,
  output logic pipe_active
);

  seq_state_t state_q, state_d;
  route_t     route_q, route_d;
  ctl_t       ctl_q, ctl_d;

  always_comb begin
    state_d = state_q;
    route_d = route_q;
    ctl_d   = ctl_q;
    unique case (state_q)
      ST_IDLE: begin
        if (!fmt_bad && fmt_good) begin
          route_d = rx_interlaced ? ROUTE_DEINT : ROUTE_BYPASS;
          state_d = ST_STOP_DN;
        end
      end
      ST_STOP_DN: begin
        ctl_d.dn_run = 1'b0;
        state_d      = ST_STOP_UP;
      end
      ST_STOP_UP: begin
        ctl_d.up_run = 1'b0;
        state_d      = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (!down_busy) state_d = ST_ROUTE;
      end
      ST_ROUTE: begin
        ctl_d.up_out0 = (route_q == ROUTE_BYPASS);
        ctl_d.up_out1 = (route_q == ROUTE_DEINT);
        ctl_d.dn_sel  = (route_q == ROUTE_DEINT);
        state_d       = ST_START_DN;
      end
      ST_START_DN: begin
        ctl_d.dn_run = 1'b1;
        state_d      = ST_TAIL_A;
      end
      ST_TAIL_A: begin
        if (route_q == ROUTE_BYPASS) ctl_d.up_run  = 1'b1;
        else                         ctl_d.dil_run = 1'b1;
        state_d = ST_TAIL_B;
      end
      ST_TAIL_B: begin
        if (route_q == ROUTE_BYPASS) ctl_d.dil_run = 1'b0;
        else                         ctl_d.up_run  = 1'b1;
        state_d = ST_RELEASE;
      end
      ST_RELEASE: begin
        ctl_d.up_discard = 1'b0;
        state_d          = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (fmt_bad) begin
          ctl_d.mix_discard = 1'b1;
          ctl_d.up_discard  = 1'b1;
          state_d           = ST_IDLE;
        end else if (fmt_good && ctl_q.mix_discard && advanced && flushed) begin
          ctl_d.mix_discard = 1'b0;
        end
      end
      default: begin
        ctl_d   = CTL_SAFE;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      route_q <= ROUTE_BYPASS;
      ctl_q   <= CTL_SAFE;
    end else begin
      state_q <= state_d;
      route_q <= route_d;
      ctl_q   <= ctl_d;
    end
  end

  always_comb begin
    ctl         = ctl_q;
    pipe_active = (state_q == ST_ACTIVE);
    sample_en   = (state_q == ST_IDLE) || (state_q == ST_ACTIVE);
    latch_en    = (state_q == ST_ACTIVE) && fmt_bad;
  end

  // R3
  drop_to_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_active && fmt_bad) |=> (ctl_q.mix_discard && ctl_q.up_discard && !pipe_active));

  // R6
  dn_before_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q.dn_run) |-> !ctl_q.up_run);

  // R6
  route_while_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({ctl_q.up_out0, ctl_q.up_out1, ctl_q.dn_sel}) |-> (!ctl_q.up_run && !ctl_q.dn_run));

  // R7
  one_up_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_q.up_out0 && ctl_q.up_out1));

  // R7
  dil_before_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctl_q.up_run) && ctl_q.dn_sel) |-> ctl_q.dil_run);

  // R7
  dil_stop_after_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_q.dil_run) |-> (ctl_q.up_run && !ctl_q.dn_sel));

  // R8
  release_when_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_q.up_discard) |-> (ctl_q.up_run && ctl_q.dn_run));

  // R9
  mix_held_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_active |-> ctl_q.mix_discard);

  // R9
  mix_release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_q.mix_discard) |-> $past(advanced && flushed && fmt_good));

endmodule

// File: rtl/vid_bypass_seq.sv
module vid_bypass_seq
  import vbs_pkg::*;
#(
  parameter int WIDTH_W      = 13,
  parameter int HEIGHT_W     = 12,
  parameter int CS_W         = 8,
  parameter int FCNT_W       = 8,
  parameter int MAX_W        = 3840,
  parameter int MAX_H        = 2160,
  parameter int Y420_CODE    = 3,
  parameter int FLUSH_FRAMES = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_locked,
  input  logic                rx_stable,
  input  logic                rx_interlaced,
  input  logic [HEIGHT_W-1:0] field0_h,
  input  logic [HEIGHT_W-1:0] field1_h,
  input  logic [WIDTH_W-1:0]  width_px,
  input  logic [CS_W-1:0]     color_code,
  input  logic                down_busy,
  input  logic [FCNT_W-1:0]   fb_count,
  output logic                up_run,
  output logic                up_out0_en,
  output logic                up_out1_en,
  output logic                up_discard,
  output logic                dn_run,
  output logic                dn_sel,
  output logic                dil_run,
  output logic                mix_discard
);

  logic fmt_bad, fmt_good;
  logic sample_en, latch_en, pipe_active;
  logic advanced, flushed;
  ctl_t ctl;

  vbs_fmt_monitor #(
    .WIDTH_W   (WIDTH_W),
    .HEIGHT_W  (HEIGHT_W),
    .CS_W      (CS_W),
    .MAX_W     (MAX_W),
    .MAX_H     (MAX_H),
    .Y420_CODE (Y420_CODE)
  ) u_fmt (
    .clk           (clk),
    .rst_n         (rst_n),
    .sample_en     (sample_en),
    .rx_locked     (rx_locked),
    .rx_stable     (rx_stable),
    .rx_interlaced (rx_interlaced),
    .field0_h      (field0_h),
    .field1_h      (field1_h),
    .width_px      (width_px),
    .color_code    (color_code),
    .fmt_bad       (fmt_bad),
    .fmt_good      (fmt_good)
  );

  vbs_flush_tracker #(
    .FCNT_W       (FCNT_W),
    .FLUSH_FRAMES (FLUSH_FRAMES)
  ) u_flush (
    .clk      (clk),
    .rst_n    (rst_n),
    .fb_count (fb_count),
    .latch_en (latch_en),
    .advanced (advanced),
    .flushed  (flushed)
  );

  vbs_route_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .fmt_bad       (fmt_bad),
    .fmt_good      (fmt_good),
    .rx_interlaced (rx_interlaced),
    .down_busy     (down_busy),
    .advanced      (advanced),
    .flushed       (flushed),
    .ctl           (ctl),
    .sample_en     (sample_en),
    .latch_en      (latch_en),
    .pipe_active   (pipe_active)
  );

  always_comb begin
    up_run      = ctl.up_run;
    up_out0_en  = ctl.up_out0;
    up_out1_en  = ctl.up_out1;
    up_discard  = ctl.up_discard;
    dn_run      = ctl.dn_run;
    dn_sel      = ctl.dn_sel;
    dil_run     = ctl.dil_run;
    mix_discard = ctl.mix_discard;
  end

endmodule

// File: tb/vid_bypass_seq_bench.sv
module vid_bypass_seq_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        rx_locked, rx_stable, rx_interlaced;
  logic [11:0] field0_h, field1_h;
  logic [12:0] width_px;
  logic [7:0]  color_code;
  logic        down_busy;
  logic [7:0]  fb_count;
  logic        up_run, up_out0_en, up_out1_en, up_discard;
  logic        dn_run, dn_sel, dil_run, mix_discard;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  vid_bypass_seq u_vid_bypass_seq (
    .clk(clk), .rst_n(rst_n),
    .rx_locked(rx_locked), .rx_stable(rx_stable), .rx_interlaced(rx_interlaced),
    .field0_h(field0_h), .field1_h(field1_h), .width_px(width_px),
    .color_code(color_code), .down_busy(down_busy), .fb_count(fb_count),
    .up_run(up_run), .up_out0_en(up_out0_en), .up_out1_en(up_out1_en),
    .up_discard(up_discard), .dn_run(dn_run), .dn_sel(dn_sel),
    .dil_run(dil_run), .mix_discard(mix_discard)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: phase counts the reconfiguration steps (0 idle, 9 running)
  int phase, route_il;
  int last_w, last_h, last_cs, last_fb, mark_fb;
  bit e_up_run, e_o0, e_o1, e_udis, e_dn_run, e_sel, e_dil, e_mix;

  always @(posedge clk or negedge rst_n) begin
    int w, h;
    bit bad, good, moved, far;
    if (!rst_n) begin
      phase = 0; route_il = 0; last_w = 0; last_h = 0; last_cs = 0;
      last_fb = 0; mark_fb = 0;
      e_up_run = 0; e_o0 = 0; e_o1 = 0; e_udis = 1;
      e_dn_run = 0; e_sel = 0; e_dil = 0; e_mix = 1;
    end else begin
      w = (color_code == 8'd3) ? 2 * int'(width_px) : int'(width_px);
      h = rx_interlaced ? int'(field0_h) + int'(field1_h) : int'(field0_h);
      bad  = !rx_locked || w != last_w || h != last_h || int'(color_code) != last_cs
             || w > 3840 || h > 2160;
      good = !bad && rx_stable;
      moved = int'(fb_count) != last_fb;
      far   = ((int'(fb_count) - mark_fb + 256) % 256) >= 10;
      if (phase == 0 || phase == 9) begin
        last_w = w; last_h = h; last_cs = int'(color_code);
      end
      last_fb = int'(fb_count);
      if (phase == 0) begin
        if (good) begin route_il = rx_interlaced; phase = 1; end
      end else if (phase == 1) begin e_dn_run = 0; phase = 2;
      end else if (phase == 2) begin e_up_run = 0; phase = 3;
      end else if (phase == 3) begin if (!down_busy) phase = 4;
      end else if (phase == 4) begin
        e_o0 = !route_il; e_o1 = route_il; e_sel = route_il; phase = 5;
      end else if (phase == 5) begin e_dn_run = 1; phase = 6;
      end else if (phase == 6) begin
        if (route_il) e_dil = 1; else e_up_run = 1;
        phase = 7;
      end else if (phase == 7) begin
        if (route_il) e_up_run = 1; else e_dil = 0;
        phase = 8;
      end else if (phase == 8) begin e_udis = 0; phase = 9;
      end else begin
        if (bad) begin
          e_mix = 1; e_udis = 1; mark_fb = int'(fb_count); phase = 0;
        end else if (good && e_mix && moved && far) begin
          e_mix = 0;
        end
      end
    end
  end

  task automatic cmp1(input bit act, input bit exp, input string tag, input string nm);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", tag, nm, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      cmp1(up_run,      e_up_run, "R6", "up_run");
      cmp1(dn_run,      e_dn_run, "R6", "dn_run");
      cmp1(up_out0_en,  e_o0,     "R7", "up_out0_en");
      cmp1(up_out1_en,  e_o1,     "R7", "up_out1_en");
      cmp1(dn_sel,      e_sel,    "R7", "dn_sel");
      cmp1(dil_run,     e_dil,    "R7", "dil_run");
      cmp1(up_discard,  e_udis,   "R8", "up_discard");
      cmp1(mix_discard, e_mix,    "R9", "mix_discard");
    end
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit act, input bit exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0b expected %0b", tag, cyc, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_fmt(input bit lk, input bit st, input bit il,
                         input int f0, input int f1, input int w, input int cs);
    rx_locked = lk; rx_stable = st; rx_interlaced = il;
    field0_h = 12'(f0); field1_h = 12'(f1); width_px = 13'(w); color_code = 8'(cs);
  endtask

  task automatic step_fb(input int n);
    for (int i = 0; i < n; i++) begin
      fb_count = fb_count + 8'd1;
      wait_cyc(3);
    end
  endtask

  initial begin
    rst_n = 1'b0; down_busy = 1'b0; fb_count = 8'd0;
    set_fmt(0, 0, 0, 0, 0, 0, 0);
    wait_cyc(3);
    // R1: safe state under reset
    chk(up_run, 0, "R1 up_run");       chk(dn_run, 0, "R1 dn_run");
    chk(up_out0_en, 0, "R1 out0");     chk(up_out1_en, 0, "R1 out1");
    chk(dn_sel, 0, "R1 dn_sel");       chk(dil_run, 0, "R1 dil_run");
    chk(up_discard, 1, "R1 up_discard"); chk(mix_discard, 1, "R1 mix_discard");
    rst_n = 1'b1;

    // 1080p progressive, drain held for a while
    down_busy = 1'b1;
    set_fmt(1, 1, 0, 1080, 0, 1920, 0);
    wait_cyc(8);
    down_busy = 1'b0;
    wait_cyc(20);
    chk(dn_sel, 0, "R5 progressive bypass");
    chk(up_out0_en, 1, "R7 bypass out0");
    chk(up_discard, 0, "R8 released");
    step_fb(9);
    chk(mix_discard, 1, "R9 held at 9 frames");
    step_fb(1);
    chk(mix_discard, 0, "R9 released at 10 frames");

    // lock loss near counter wrap
    fb_count = 8'd250;
    wait_cyc(3);
    set_fmt(0, 0, 0, 1080, 0, 1920, 0);
    wait_cyc(3);
    chk(mix_discard, 1, "R3 lock loss mixer");
    chk(up_discard, 1, "R3 lock loss upstream");

    // interlaced 2x540, long drain
    down_busy = 1'b1;
    set_fmt(1, 1, 1, 540, 540, 1920, 0);
    wait_cyc(10);
    chk(dn_run, 0, "R6 downstream stopped during drain");
    chk(up_run, 0, "R6 upstream stopped during drain");
    chk(dn_sel, 0, "R6 route unchanged during drain");
    wait_cyc(5);
    down_busy = 1'b0;
    wait_cyc(20);
    chk(dn_sel, 1, "R5 interlaced deinterlace");
    chk(up_out1_en, 1, "R7 deint out1");
    chk(dil_run, 1, "R7 deint running");
    step_fb(9);
    chk(mix_discard, 1, "R10 held before wrap threshold");
    step_fb(1);
    chk(mix_discard, 0, "R10 released across wrap");

    // field height change
    set_fmt(1, 1, 1, 540, 541, 1920, 0);
    wait_cyc(2);
    chk(mix_discard, 1, "R3 height change");
    wait_cyc(25);
    chk(up_discard, 0, "R8 rebuilt after height change");

    // lock with stable flag low: no action either way
    set_fmt(1, 0, 1, 540, 541, 1920, 0);
    wait_cyc(20);
    chk(up_discard, 0, "R2 running kept without stable flag");
    set_fmt(0, 0, 1, 540, 541, 1920, 0);
    wait_cyc(3);
    set_fmt(1, 0, 1, 540, 541, 1920, 0);
    wait_cyc(20);
    chk(dn_run, 1, "R2 no restart without stable flag");
    chk(up_discard, 1, "R2 discard kept without stable flag");

    // 4:2:0 at 1920 -> 3840 wide, progressive 2160
    set_fmt(1, 1, 0, 2160, 0, 1920, 3);
    wait_cyc(30);
    chk(dn_sel, 0, "R4 420 doubled width accepted, bypass");
    chk(dil_run, 0, "R5 4K progressive bypass");
    // 1921 at 4:2:0 is too wide after doubling
    set_fmt(1, 1, 0, 2160, 0, 1921, 3);
    wait_cyc(25);
    chk(up_discard, 1, "R4 doubled width over limit");
    chk(dn_run, 1, "R3 no restart while too wide");

    // height over limit
    set_fmt(1, 1, 0, 2200, 0, 3840, 0);
    wait_cyc(25);
    chk(dn_run, 1, "R3 no restart while too tall");
    chk(up_discard, 1, "R3 discard kept while too tall");

    // 4K progressive 4:4:4
    set_fmt(1, 1, 0, 2160, 0, 3840, 0);
    wait_cyc(30);
    chk(up_discard, 0, "R8 4K pipe running");
    chk(dn_sel, 0, "R5 4K bypass");
    fb_count = fb_count + 8'd40;
    wait_cyc(3);
    chk(mix_discard, 0, "R9 jump past threshold releases");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule